// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the slowly varying frequency-offset word that a fractional feedback divider in a clock synthesizer follows in order to sweep its output clock across a chosen band. Lowering the peak spectral energy of the clock this way also lowers the peak emissions of every signal timed by it. The block steps a phase counter on a sample tick derived from the output clock. It folds the phase into a quarter-wave shape and scales the shape by the selected spread depth. It then presents the result as a signed offset in parts per 100000 of the nominal frequency.

A 3-bit width code selects one of four depths and chooses between down-spread and center-spread. An active-low enable switches the modulation on. Both selections are taken only when a modulation period ends, so the sweep never jumps in mid-period. A single-cycle flag marks the first phase of every period. The shape rises faster near its extremes than a plain triangle does, which approximates the profile that best flattens the emission spectrum. The unmodulated reference path is outside this block and never receives the offset.

Top module: `ssm_profile_gen`

## Requirements
- R1: While `rst_n` is low, `freq_ofs` is 0 and `period_start` is 0. The latched configuration resets to disabled, down-spread, depth code 0, and the phase resets to 0.
- R2: The phase advances by one on each clock edge that samples `tick` high. One period is 1024 ticks. On the edge where the phase wraps from 1023 to 0, `period_start` goes high for exactly one clock. It is low on every other cycle.
- R3: `width_sel[2:1]` = d selects the half-depth H = 625 << d parts per 100000. The total spread is therefore 1.25 %, 2.5 %, 5 % or 10 % for d = 0, 1, 2, 3.
- R4: With `width_sel[0]` = 0 (down-spread), the offset is C − H, where C is the center value of R6. It spans 0 down to −2H, so it never exceeds 0.
- R5: With `width_sel[0]` = 1 (center-spread), the offset is C. It reaches +H at phase 256 and −H at phase 768, and its sum over one full period is exactly 0.
- R6: Shape: let q = phase[9:8] and u = phase[7:0]. Then x = 256 − u when q[0] = 1, and x = u otherwise. The shape points are L(k) = 256k + k³ for k = 0..16. The shape is f(x) = L(s) + ((L(s+1) − L(s))·r >> 4), where s = x >> 4 and r = x & 15. The magnitude is m = (f·H) >> 13, and C = −m when q[1] = 1, +m otherwise.
- R7: When the latched enable is off (`spread_en_n` was high at the last wrap, or no wrap has occurred since reset), `freq_ofs` is 0.
- R8: `width_sel` and `spread_en_n` are sampled only on the edge where the phase wraps. A change at any other time has no effect on `freq_ofs` before that edge.
- R9: On an edge where `tick` is low, `freq_ofs` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample tick; advances the phase by one |
| width_sel | input | 3 | Bits 2:1 depth code, bit 0 center-spread select |
| spread_en_n | input | 1 | Modulation enable, active low |
| freq_ofs | output | OFS_W | Signed frequency offset in parts per 100000 |
| period_start | output | 1 | High for one clock at phase 0 of each period |

## Verification
Every result of this block is due on the same clock edge that samples the causing tick: the offset and the period flag are registered from next-state values, so the phase and the offset move together. A configuration change only shows up on the edge of the next wrap. The bench drives inputs shortly after the falling edge and advances a behavioural reference (phase count, latched configuration, shape formula) on each rising edge. It compares both outputs at the following falling edge, which keeps every comparison one register stage from its stimulus. On cycles without a tick, the bench compares the offset with its value one cycle earlier. It also collects per-period extremes and sums between period flags to check peaks, floors and the zero mean.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   // Configuration captured at each period boundary.
   typedef struct packed {
      logic       en;      // modulation active
      logic       center;  // 1: symmetric band, 0: band below nominal
      logic [1:0] depth;   // half-depth = base << depth
   } ssm_cfg_t;

   // Normalized quarter-wave shape point k of n, full scale 2**fs_w.
   // Curved variant: (n*n*k + k*k*k) / (2*n*n*n), slope rising toward the peak.
   // Linear variant: k / n (plain triangle).
   function automatic longint shape_point(int k, int n, int fs_w, bit curved);
      longint kk;
      longint nn;
      kk = (k > n) ? longint'(n) : longint'(k);
      nn = longint'(n);
      if (curved)
         return ((nn * nn * kk + kk * kk * kk) << fs_w) / (2 * nn * nn * nn);
      else
         return (kk << fs_w) / nn;
   endfunction

endpackage

// File: rtl/ssm_phase_ctr.sv
module ssm_phase_ctr #(
   parameter int PHASE_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   output logic [PHASE_W-1:0] phase_nxt,
   output logic [PHASE_W-1:0] phase_q,
   output logic               wrap,
   output logic               start_q
);

   always_comb begin
      wrap      = tick & (&phase_q);
      phase_nxt = tick ? phase_q + PHASE_W'(1) : phase_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         start_q <= 1'b0;
      end else begin
         phase_q <= phase_nxt;
         start_q <= wrap;
      end
   end

   // the flag marks phase zero only
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (phase_q == '0)); // R2

   // a flag never lasts two cycles
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q); // R2

endmodule

// File: rtl/ssm_cfg_latch.sv
module ssm_cfg_latch (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   input  ssm_pkg::ssm_cfg_t cfg_in,
   output ssm_pkg::ssm_cfg_t cfg_nxt,
   output ssm_pkg::ssm_cfg_t cfg_q
);

   always_comb begin
      cfg_nxt = wrap ? cfg_in : cfg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_nxt;
   end

endmodule

// File: rtl/ssm_shape.sv
module ssm_shape #(
   parameter int PHASE_W = 10,
   parameter int SEG_W   = 4,
   parameter int FS_W    = 13,
   parameter bit CURVED  = 1'b1
) (
   input  logic [PHASE_W-1:0] phase,
   output logic [FS_W:0]      mag,
   output logic               neg
);

   localparam int Q_W    = PHASE_W - 2;        // bits of position in a quarter
   localparam int X_W    = PHASE_W - 1;        // folded position 0..2**Q_W
   localparam int FRAC_W = Q_W - SEG_W;        // interpolation fraction bits
   localparam int IDX_W  = SEG_W + 1;          // segment index incl. endpoint
   localparam int N_PTS  = 1 << SEG_W;
   localparam int LUT_N  = 1 << IDX_W;
   localparam int LUT_W  = FS_W + 1;
   localparam int PRD_W  = LUT_W + FRAC_W;

   logic [LUT_W-1:0] lut [LUT_N];

   generate
      for (genvar k = 0; k < LUT_N; k++) begin : g_pt
         if (CURVED) begin : g_curve
            assign lut[k] = LUT_W'(ssm_pkg::shape_point(k, N_PTS, FS_W, 1'b1));
         end else begin : g_lin
            assign lut[k] = LUT_W'(ssm_pkg::shape_point(k, N_PTS, FS_W, 1'b0));
         end
      end
   endgenerate

   logic [Q_W-1:0]    u;
   logic [X_W-1:0]    x;
   logic [IDX_W-1:0]  seg;
   logic [IDX_W-1:0]  seg_up;
   logic [FRAC_W-1:0] fr;
   logic [LUT_W-1:0]  lo;
   logic [LUT_W-1:0]  hi;
   logic [LUT_W-1:0]  diff;
   logic [PRD_W-1:0]  prod;

   always_comb begin
      u      = phase[Q_W-1:0];
      neg    = phase[PHASE_W-1];
      // odd quarters run the shape backwards from the peak
      x      = phase[PHASE_W-2] ? ((X_W'(1) << Q_W) - X_W'(u)) : X_W'(u);
      seg    = x[X_W-1:FRAC_W];
      fr     = x[FRAC_W-1:0];
      seg_up = seg + IDX_W'(1);
      lo     = lut[seg];
      hi     = lut[seg_up];
      diff   = hi - lo;
      prod   = PRD_W'(diff) * PRD_W'(fr);
      mag    = lo + prod[FRAC_W +: LUT_W];
   end

endmodule

// File: rtl/ssm_scale.sv
module ssm_scale #(
   parameter int FS_W      = 13,
   parameter int OFS_W     = 16,
   parameter int BASE_HALF = 625
) (
   input  logic [FS_W:0]            mag,
   input  logic                     neg,
   input  ssm_pkg::ssm_cfg_t        cfg,
   output logic signed [OFS_W-1:0]  ofs
);

   localparam int HALF_W = $clog2(BASE_HALF * 8 + 1);
   localparam int PRD_W  = FS_W + 1 + HALF_W;

   logic [HALF_W-1:0]        half;
   logic [PRD_W-1:0]         prod;
   logic [HALF_W-1:0]        scaled;
   logic signed [OFS_W-1:0]  s_mag;
   logic signed [OFS_W-1:0]  s_half;
   logic signed [OFS_W-1:0]  centre_v;

   always_comb begin
      half     = HALF_W'(BASE_HALF) << cfg.depth;
      prod     = PRD_W'(mag) * PRD_W'(half);
      scaled   = prod[FS_W +: HALF_W];
      s_mag    = signed'(OFS_W'(scaled));
      s_half   = signed'(OFS_W'(half));
      // sign applied after truncation keeps the two half-waves exact mirrors
      centre_v = neg ? -s_mag : s_mag;
      if (!cfg.en)         ofs = '0;
      else if (cfg.center) ofs = centre_v;
      else                 ofs = centre_v - s_half;
   end

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen #(
   parameter int PHASE_W   = 10,
   parameter int SEG_W     = 4,
   parameter int FS_W      = 13,
   parameter int OFS_W     = 16,
   parameter int BASE_HALF = 625,
   parameter bit CURVED    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [2:0]              width_sel,
   input  logic                    spread_en_n,
   output logic signed [OFS_W-1:0] freq_ofs,
   output logic                    period_start
);

   localparam int FRAC_W  = PHASE_W - 2 - SEG_W;
   localparam int SPAN_W  = $clog2(BASE_HALF * 16 + 1) + 1;

   generate
      if (FRAC_W < 1) begin : g_bad_seg
         $error("SEG_W leaves no interpolation bits for this PHASE_W");
      end
      if (OFS_W < SPAN_W) begin : g_bad_ofs
         $error("OFS_W cannot hold the deepest down-spread value");
      end
      if (FS_W < 4) begin : g_bad_fs
         $error("FS_W too small for a useful shape resolution");
      end
   endgenerate

   ssm_pkg::ssm_cfg_t cfg_in;
   ssm_pkg::ssm_cfg_t cfg_nxt;
   ssm_pkg::ssm_cfg_t cfg_q;
   logic [PHASE_W-1:0] phase_nxt;
   logic [PHASE_W-1:0] phase_q;
   logic               wrap;
   logic [FS_W:0]      mag;
   logic               neg;
   logic signed [OFS_W-1:0] ofs_nxt;

   always_comb begin
      cfg_in.en     = ~spread_en_n;
      cfg_in.center = width_sel[0];
      cfg_in.depth  = width_sel[2:1];
   end

   ssm_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .phase_nxt (phase_nxt),
      .phase_q   (phase_q),
      .wrap      (wrap),
      .start_q   (period_start)
   );

   ssm_cfg_latch u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .cfg_in  (cfg_in),
      .cfg_nxt (cfg_nxt),
      .cfg_q   (cfg_q)
   );

   ssm_shape #(
      .PHASE_W (PHASE_W),
      .SEG_W   (SEG_W),
      .FS_W    (FS_W),
      .CURVED  (CURVED)
   ) u_shape (
      .phase (phase_nxt),
      .mag   (mag),
      .neg   (neg)
   );

   ssm_scale #(
      .FS_W      (FS_W),
      .OFS_W     (OFS_W),
      .BASE_HALF (BASE_HALF)
   ) u_scale (
      .mag (mag),
      .neg (neg),
      .cfg (cfg_nxt),
      .ofs (ofs_nxt)
   );

   // output register built from next-state values: phase and offset move together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) freq_ofs <= '0;
      else        freq_ofs <= ofs_nxt;
   end

   AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> $stable(cfg_q)); // R8

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.en |-> (freq_ofs == '0)); // R7

   AST_DOWN_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.en && !cfg_q.center) |-> (freq_ofs <= 0)); // R4

   AST_BAND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.en |-> ((int'(freq_ofs) >= -2 * (BASE_HALF << cfg_q.depth)) &&
                    (int'(freq_ofs) <= (BASE_HALF << cfg_q.depth)))); // R3

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(freq_ofs)); // R9

endmodule

// File: tb/tb_ssm_profile_gen.sv
module tb_ssm_profile_gen;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              tick;
   logic [2:0]        width_sel;
   logic              spread_en_n;
   logic signed [15:0] freq_ofs;
   logic              period_start;

   ssm_profile_gen dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .width_sel    (width_sel),
      .spread_en_n  (spread_en_n),
      .freq_ofs     (freq_ofs),
      .period_start (period_start)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic int pt(int k);
      return 256 * k + k * k * k;
   endfunction

   function automatic int model_ofs(int ph, bit en, bit ctr, int dep);
      int q, u, x, s, r, f, h, m, c;
      if (!en) return 0;
      q = ph / 256;
      u = ph % 256;
      x = (q % 2 == 1) ? 256 - u : u;
      s = x / 16;
      r = x % 16;
      f = pt(s) + (((pt(s + 1 > 16 ? 16 : s + 1) - pt(s)) * r) / 16);
      h = 625 << dep;
      m = (f * h) / 8192;
      c = (q >= 2) ? -m : m;
      return ctr ? c : c - h;
   endfunction

   int m_ph;
   bit m_en, m_ctr, m_start, tick_seen;
   int m_dep;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_en <= 0; m_ctr <= 0; m_dep <= 0; m_start <= 0; tick_seen <= 0;
      end else begin
         tick_seen <= tick;
         if (tick) begin
            if (m_ph == 1023) begin
               m_ph    <= 0;
               m_en    <= !spread_en_n;
               m_ctr   <= width_sel[0];
               m_dep   <= int'(width_sel[2:1]);
               m_start <= 1;
            end else begin
               m_ph    <= m_ph + 1;
               m_start <= 0;
            end
         end else begin
            m_start <= 0;
         end
      end
   end

   // ---------------- monitor ----------------
   int prev_ofs = 0;
   longint s_sum;
   int s_min, s_max, s_cnt, s_dep;
   bit s_have = 0, s_en, s_ctr;

   task automatic eval_period();
      int h;
      h = 625 << s_dep;
      check(s_cnt == 1024, "R2 period length", s_cnt, 1024);
      if (!s_en) begin
         check(s_min == 0 && s_max == 0, "R7 disabled", s_max, 0);
      end else if (s_ctr) begin
         check(s_max == h, "R3 center peak", s_max, h);
         check(s_min == -h, "R5 center trough", s_min, -h);
         check(s_sum == 0, "R5 zero mean", int'(s_sum), 0);
      end else begin
         check(s_max == 0, "R4 down top", s_max, 0);
         check(s_min == -2 * h, "R3 down floor", s_min, -2 * h);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp;
         bit pend;
         string lbl;
         exp  = model_ofs(m_ph, m_en, m_ctr, m_dep);
         pend = (spread_en_n != !m_en) || (width_sel != {m_dep[1:0], m_ctr});
         lbl  = pend ? "R8 cfg held" : (!m_en ? "R7 off" : (m_ctr ? "R6 shape" : "R4 down"));
         check(int'(freq_ofs) == exp, lbl, int'(freq_ofs), exp);
         check(period_start == m_start, "R2 flag", int'(period_start), int'(m_start));
         if (!tick_seen) begin
            check(int'(freq_ofs) == prev_ofs, "R9 hold", int'(freq_ofs), prev_ofs);
         end else if (period_start) begin
            if (s_have) eval_period();
            s_have = 1; s_sum = freq_ofs; s_min = freq_ofs; s_max = freq_ofs; s_cnt = 1;
            s_en = m_en; s_ctr = m_ctr; s_dep = m_dep;
         end else begin
            s_sum += freq_ofs;
            if (int'(freq_ofs) < s_min) s_min = freq_ofs;
            if (int'(freq_ofs) > s_max) s_max = freq_ofs;
            s_cnt++;
         end
         prev_ofs = freq_ofs;
      end
   end

   // ---------------- stimulus ----------------
   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic set_cfg(bit en, bit ctr, int dep);
      @(negedge clk); #1;
      spread_en_n = !en;
      width_sel   = {dep[1:0], ctr};
   endtask

   // pat 0: tick every cycle, 1: every third cycle, 2: random
   task automatic run(int n_ticks, int pat);
      int got = 0;
      int cyc = 0;
      while (got < n_ticks) begin
         @(negedge clk); #1;
         case (pat)
            0:       tick = 1'b1;
            1:       tick = (cyc % 3 == 0);
            default: tick = 1'($urandom % 2);
         endcase
         if (tick) got++;
         cyc++;
      end
      @(negedge clk); #1;
      tick = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      rst_n = 0; tick = 0; width_sel = 3'b000; spread_en_n = 1;
      repeat (3) @(negedge clk);
      check(freq_ofs == 0, "R1 reset offset", int'(freq_ofs), 0);
      check(period_start == 0, "R1 reset flag", int'(period_start), 0);
      #1 rst_n = 1;
      run(600, 0);
      set_cfg(1, 1, 0);          // mid-period change, R8
      run(1500, 0);
      for (int d = 0; d < 4; d++) begin
         set_cfg(1, 1, d);
         run(2048, 0);
      end
      for (int d = 0; d < 4; d++) begin
         set_cfg(1, 0, d);
         run(2048, 0);
      end
      set_cfg(1, 1, 2);
      run(2048, 1);
      set_cfg(1, 0, 3);
      run(2048, 2);
      set_cfg(0, 1, 3);
      run(2048, 0);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule